// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Unit

This block watches a bank of already-synchronised input pins and turns selected transitions or levels on them into latched interrupt status. Each pin carries its own 4-bit sense selector choosing rising edge, falling edge, high level, low level or either edge. A per-pin detect gate decides whether the pin is watched at all. Detected events set a sticky status bit that software clears by writing ones to an acknowledge register.

An unmask register, changed only through a set-by-one and a clear-by-one write port, decides which status bits reach the CPU. A single registered interrupt line is the OR of all unmasked status bits. Software reads the masked status, services the lowest set bit, acknowledges it, and repeats until the masked view reads zero. To change a pin's sense type, software closes the pin's detect gate, rewrites the field, acknowledges any stale status and reopens the gate.

The register port is a simple single-cycle write strobe with a shared address. Read data is registered and appears one cycle after the address is presented. It shows register contents as they stood before that clock edge.

Top module: `irq_sense_unit`

## Requirements
- R1: After a synchronous reset every register reads zero and `irq_out` is low.
- R2: Pin n's sense selector is the 4-bit field starting at bit 4·(n mod 8) of the configuration word at address 0x40 + 4·(n/8), and each configuration word reads back exactly as written.
- R3: Selector value 8 latches the pin's status bit on a 0→1 transition of the pin, and the bit then holds until acknowledged.
- R4: Selector value 9 latches the status bit on a 1→0 transition of the pin.
- R5: Selector value 10 sets the status bit in every cycle the pin is high, so an acknowledge has no lasting effect while the pin stays high; the bit stays latched after the pin drops until acknowledged.
- R6: Selector value 11 sets the status bit in every cycle the pin is low.
- R7: Selector value 12 latches the status bit on either transition of the pin.
- R8: Selector values 0–7 and 13–15 never set a status bit.
- R9: The detect gate at address 0x14 is read/write; a pin whose gate bit is 0 sets no status, whatever its selector.
- R10: Writing ones to address 0x18 sets the corresponding unmask bits and writing ones to 0x1C clears them; zero bits leave them unchanged, and both addresses read back the unmask register.
- R11: Writing ones to address 0x28 clears the corresponding status bits, except that an event detected in the same cycle wins and leaves its bit set.
- R12: Address 0x20 reads the raw status and address 0x24 reads the raw status ANDed with the unmask register.
- R13: `irq_out` is high exactly when some status bit is both set and unmasked, in the same cycle as the status register holding that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Synchronised pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is an acknowledge colliding with a fresh edge on the same pin in the same cycle, since the pin change and the acknowledge write must land on one clock edge. The bench drives the pin transition and the acknowledge write together from the same negative clock edge after first latching the bit, then reads the raw status back. Level sense against acknowledge is reached by holding a pin at its active level across the acknowledge write and only releasing it afterwards.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  localparam int SEL_W    = 4;
  localparam int A_DETEN  = 'h14;
  localparam int A_MSET   = 'h18;
  localparam int A_MCLR   = 'h1C;
  localparam int A_RAW    = 'h20;
  localparam int A_MASKED = 'h24;
  localparam int A_ACK    = 'h28;
  localparam int A_SENSE  = 'h40;

  typedef enum logic [SEL_W-1:0] {
    SNS_RISE = 4'h8,
    SNS_FALL = 4'h9,
    SNS_HIGH = 4'hA,
    SNS_LOW  = 4'hB,
    SNS_BOTH = 4'hC
  } sense_e;

  function automatic logic sense_hit(logic [SEL_W-1:0] sel, logic cur, logic old);
    logic hit;
    case (sel)
      SNS_RISE: hit = cur & ~old;
      SNS_FALL: hit = ~cur & old;
      SNS_HIGH: hit = cur;
      SNS_LOW:  hit = ~cur;
      SNS_BOTH: hit = cur ^ old;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/irq_sense_detect.sv
module irq_sense_detect
  import irq_sense_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       pin_i,
  input  logic [NPINS*SEL_W-1:0] sel_i,
  input  logic [NPINS-1:0]       gate_i,
  output logic [NPINS-1:0]       evt_o
);

  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign evt_o[i] = gate_i[i] & sense_hit(sel_i[i*SEL_W +: SEL_W], pin_i[i], prev_q[i]);
  end

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
  import irq_sense_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NPINS-1:0]         evt_i,
  output logic [NPINS-1:0]         gate_q,
  output logic [NPINS-1:0]         mask_q,
  output logic [NPINS-1:0]         raw_q,
  output logic [NPINS*SEL_W-1:0]   sel_q,
  output logic [DATA_W-1:0]        rdata_q,
  output logic                     irq_q
);

  localparam int PER_WORD = DATA_W / SEL_W;
  localparam int NWORDS   = NPINS / PER_WORD;

  logic [NPINS-1:0]  wlo;
  logic [NPINS-1:0]  set_v, clr_v, ack_v;
  logic [NPINS-1:0]  mask_d, raw_d;
  logic [DATA_W-1:0] rd_d;

  assign wlo   = wdata[NPINS-1:0];
  assign set_v = (wr_en && addr == ADDR_W'(A_MSET)) ? wlo : '0;
  assign clr_v = (wr_en && addr == ADDR_W'(A_MCLR)) ? wlo : '0;
  assign ack_v = (wr_en && addr == ADDR_W'(A_ACK))  ? wlo : '0;

  assign mask_d = (mask_q | set_v) & ~clr_v;
  assign raw_d  = (raw_q & ~ack_v) | evt_i;

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(A_DETEN)) rd_d = DATA_W'(gate_q);
    if (addr == ADDR_W'(A_MSET) || addr == ADDR_W'(A_MCLR)) rd_d = DATA_W'(mask_q);
    if (addr == ADDR_W'(A_RAW)) rd_d = DATA_W'(raw_q);
    if (addr == ADDR_W'(A_MASKED)) rd_d = DATA_W'(raw_q & mask_q);
    for (int r = 0; r < NWORDS; r++) begin
      if (addr == ADDR_W'(A_SENSE + 4 * r)) rd_d = sel_q[r*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= '0;
      mask_q  <= '0;
      raw_q   <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(A_DETEN)) gate_q <= wlo;
      for (int r = 0; r < NWORDS; r++) begin
        if (wr_en && addr == ADDR_W'(A_SENSE + 4 * r)) sel_q[r*DATA_W +: DATA_W] <= wdata;
      end
      mask_q  <= mask_d;
      raw_q   <= raw_d;
      rdata_q <= rd_d;
      irq_q   <= |(raw_d & mask_d);
    end
  end

endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
  import irq_sense_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out
);

  logic [NPINS-1:0]       evt_w, gate_w, mask_w, raw_w;
  logic [NPINS*SEL_W-1:0] sel_w;

  irq_sense_detect #(.NPINS(NPINS)) u_det (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_in),
    .sel_i  (sel_w),
    .gate_i (gate_w),
    .evt_o  (evt_w)
  );

  irq_sense_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .evt_i   (evt_w),
    .gate_q  (gate_w),
    .mask_q  (mask_w),
    .raw_q   (raw_w),
    .sel_q   (sel_w),
    .rdata_q (rdata),
    .irq_q   (irq_out)
  );

endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk
  import irq_sense_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_out,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  den,
  input logic [NPINS-1:0]  mask,
  input logic [NPINS-1:0]  raw
);

  logic             is_ack, is_set, is_clr;
  logic [NPINS-1:0] wlo;

  assign wlo    = wdata[NPINS-1:0];
  assign is_ack = wr_en && addr == ADDR_W'(A_ACK);
  assign is_set = wr_en && addr == ADDR_W'(A_MSET);
  assign is_clr = wr_en && addr == ADDR_W'(A_MCLR);

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(raw & mask)); // R13

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw & $past(evt)) == $past(evt))); // R11

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    is_ack |=> ((raw & $past(wlo & ~evt)) == '0)); // R11

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!is_ack && evt == '0) |=> $stable(raw)); // R3

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (evt & ~den) == '0); // R9

  AST_UNMASK_SET: assert property (@(posedge clk) disable iff (rst)
    is_set |=> ((mask & $past(wlo)) == $past(wlo))); // R10

  AST_UNMASK_CLR: assert property (@(posedge clk) disable iff (rst)
    is_clr |=> ((mask & $past(wlo)) == '0)); // R10

endmodule

bind irq_sense_unit irq_sense_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq_out (irq_out),
  .evt     (evt_w),
  .den     (gate_w),
  .mask    (mask_w),
  .raw     (raw_w)
);

// File: tb/irq_sense_unit_test.sv
`timescale 1ns/1ps
module irq_sense_unit_test;

  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_sense_unit uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  // behavioural reference
  int          m_sel [NP];
  logic [31:0] m_den, m_mask, m_raw, m_prev, m_rdata;
  logic        m_irq, m_valid, m_rd_rst;
  logic [7:0]  m_rd_addr;

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      8'h14: v = m_den;
      8'h18, 8'h1C: v = m_mask;
      8'h20: v = m_raw;
      8'h24: v = m_raw & m_mask;
      8'h40, 8'h44, 8'h48, 8'h4C:
        for (int k = 0; k < 8; k++) v[k*4 +: 4] = 4'(m_sel[(a - 8'h40) * 2 + k]);
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    logic [31:0] ev, ack, rd;
    if (rst) begin
      for (int i = 0; i < NP; i++) m_sel[i] = 0;
      m_den = '0; m_mask = '0; m_raw = '0; m_prev = '0;
      m_rdata = '0; m_irq = 1'b0; m_rd_rst = 1'b1;
    end else begin
      rd = m_read(addr);
      ev = '0;
      for (int i = 0; i < NP; i++) begin
        logic c, o, h;
        c = pin_in[i]; o = m_prev[i];
        case (m_sel[i])
          8:  h = c && !o;
          9:  h = !c && o;
          10: h = c;
          11: h = !c;
          12: h = c != o;
          default: h = 1'b0;
        endcase
        if (m_den[i] && h) ev[i] = 1'b1;
      end
      ack = (wr_en && addr == 8'h28) ? wdata : '0;
      if (wr_en) begin
        if (addr == 8'h14) m_den = wdata;
        if (addr == 8'h18) m_mask = m_mask | wdata;
        if (addr == 8'h1C) m_mask = m_mask & ~wdata;
        if (addr >= 8'h40 && addr <= 8'h4C && addr[1:0] == 2'b00)
          for (int k = 0; k < 8; k++) m_sel[(addr - 8'h40) * 2 + k] = int'(wdata[k*4 +: 4]);
      end
      m_raw = (m_raw & ~ack) | ev;
      m_irq = |(m_raw & m_mask);
      m_rdata = rd;
      m_prev = pin_in;
      m_rd_rst = 1'b0;
    end
    m_rd_addr = addr;
    m_valid = 1'b1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] a, logic in_rst);
    if (in_rst) return "R1";
    case (a)
      8'h14: return "R9";
      8'h18, 8'h1C: return "R10";
      8'h20, 8'h24: return "R12";
      8'h28: return "R11";
      default: return "R2";
    endcase
  endfunction

  // cycle-by-cycle comparison against the reference
  initial m_valid = 1'b0;
  always @(negedge clk) begin
    if (m_valid) begin
      chk(tag_of(m_rd_addr, m_rd_rst), rdata, m_rdata);
      chk("R13", 32'(irq_out), 32'(m_irq));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_pins(logic [7:0] a, logic [31:0] d, logic [31:0] p);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; pin_in = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic pins(logic [31:0] p);
    @(negedge clk);
    pin_in = p;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", 32'(irq_out), 32'h0);
    rd(8'h14, v); chk("R1", v, 32'h0);
    rd(8'h18, v); chk("R1", v, 32'h0);
    rd(8'h20, v); chk("R1", v, 32'h0);
    rd(8'h40, v); chk("R1", v, 32'h0);

    // R2 selector placement and readback
    wr(8'h40, 32'h003C_BA98);
    wr(8'h44, 32'h0000_00D0);
    wr(8'h4C, 32'h8000_0000);
    rd(8'h40, v); chk("R2", v, 32'h003C_BA98);
    rd(8'h44, v); chk("R2", v, 32'h0000_00D0);
    rd(8'h48, v); chk("R2", v, 32'h0);
    rd(8'h4C, v); chk("R2", v, 32'h8000_0000);

    // R10 unmask set/clear
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0000_0002);
    wr(8'h18, 32'h0000_0000);
    rd(8'h18, v); chk("R10", v, 32'hFFFF_FFFD);
    rd(8'h1C, v); chk("R10", v, 32'hFFFF_FFFD);

    // R9 gate open; R6 low level fires at once on pin 3
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R9", v, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R6", v, 32'h0000_0008);

    pins(32'h0000_0235);
    rd(8'h20, v);
    chk("R3", 32'(v[0]), 32'h1);
    chk("R5", 32'(v[2]), 32'h1);
    chk("R7", 32'(v[4]), 32'h1);
    chk("R8", v & 32'h0000_0220, 32'h0);
    chk("R12", v, 32'h0000_001D);

    // R11 acknowledge; R5/R6 level bits survive while active
    wr(8'h28, 32'h0000_001F);
    rd(8'h20, v); chk("R11", v, 32'h0000_000C);

    pins(32'h0000_0002);
    rd(8'h20, v); chk("R7", v, 32'h0000_001C);

    pins(32'h0000_0000);
    rd(8'h20, v); chk("R4", v, 32'h0000_001E);
    rd(8'h24, v); chk("R12", v, 32'h0000_001C);
    chk("R13", 32'(irq_out), 32'h1);

    wr(8'h28, 32'h0000_0004);
    rd(8'h20, v); chk("R5", v, 32'h0000_001A);

    // R11 collision: event and acknowledge on one edge
    pins(32'h0000_0001);
    pins(32'h0000_0000);
    wr_pins(8'h28, 32'h0000_0001, 32'h0000_0001);
    rd(8'h20, v); chk("R11", 32'(v[0]), 32'h1);
    wr(8'h28, 32'h0000_0001);
    rd(8'h20, v); chk("R3", 32'(v[0]), 32'h0);

    // R9 closed gate blocks detection
    wr(8'h14, 32'hFFFF_FFFE);
    pins(32'h0000_0000);
    pins(32'h0000_0001);
    rd(8'h20, v); chk("R9", 32'(v[0]), 32'h0);

    // R13 output follows unmasked status
    wr(8'h1C, 32'hFFFF_FFFF);
    chk("R13", 32'(irq_out), 32'h0);
    rd(8'h24, v); chk("R12", v, 32'h0);
    wr(8'h18, 32'h0000_0008);
    chk("R13", 32'(irq_out), 32'h1);
    rd(8'h18, v); chk("R10", v, 32'h0000_0008);

    // R2 last word, top field
    pins(32'h8000_0001);
    rd(8'h20, v); chk("R2", 32'(v[31]), 32'h1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule